// File: doc/BRIEF.md
# Programmable Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. Each frame's shape is set at run time by a six-bit line-control word. The word selects the data length (5 to 8 bits), whether a parity bit is added and how it is formed, and whether one or two stop bits close the frame. A divisor-driven timer sets the bit period. Bytes arrive on a valid/ready handshake. An optional clear-to-send input, active low, keeps a new frame from starting while the far end is not ready.

The block can also send a break, which holds the line low for as long as one frame in the current format lasts. A break request that arrives during a frame waits until that frame's last stop bit has finished. A one-cycle done pulse marks the end of the break. After it, normal transmission goes on with whatever byte is offered next.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset and between frames the line `txd` is 1 and `in_ready` is 1, provided no break is requested and flow control does not block.
- R2: A frame starts in the clock after `in_valid && in_ready`. It sends a start bit of 0, then the data bits least significant first. The count of data bits is 5 + `lcr[1:0]` (00 gives 5, 11 gives 8).
- R3: Parity follows `lcr[5:3]`. 0xx gives no parity bit. 100 gives odd parity and 101 gives even parity, both over the data bits sent. 110 sends a constant 1 and 111 sends a constant 0. The parity bit follows the last data bit.
- R4: `lcr[2]` = 0 sends one stop bit of 1 and `lcr[2]` = 1 sends two.
- R5: Every bit, breaks included, lasts exactly (`divisor` + 1) × 16 clock cycles.
- R6: `in_ready` is 0 from the accepting edge until the last stop bit has completed.
- R7: `lcr` and `divisor` are captured when a frame or break starts. Changing them later has no effect on that frame.
- R8: When `flow_en` is 1 and `cts_n` is 1, no frame starts and `in_ready` is 0. A frame starts once `cts_n` is 0.
- R9: A `brk_req` pulse drives `txd` to 0 for a full frame duration in the current format. If a frame is in progress, the break starts only after that frame completes. `brk_done` pulses high for one cycle in the clock after the break ends.
- R10: A pending or present break request holds `in_ready` at 0, so the break goes before any offered byte. After the break, the offered byte is sent as a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be accepted this cycle |
| in_data | input | 8 | Byte to send |
| lcr | input | 6 | Line control: [1:0] length, [2] stops, [5:3] parity |
| divisor | input | 16 | Bit period is (divisor+1)×16 clocks |
| flow_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low |
| brk_req | input | 1 | Request a break |
| brk_done | output | 1 | One-cycle pulse at the end of a break |
| txd | output | 1 | Serial output, idles high |

## Verification
The checker tests on every cycle the relationships that hold at any moment. These are: a high idle line, a low start bit after each accept, ready held low while busy, and the clear-to-send gate at frame start. It also checks that the line stays low through a break, that `brk_done` comes only from a break, and that a break request blocks ready. The exact bit sequence for each format, the bit period, the capture of `lcr` and `divisor` at frame start, and the queuing of a break behind a running frame can only be shown by the bench's reference model. That model builds the expected waveform clock by clock for each scenario.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  localparam int FRAME_MAX = 12;
  localparam int IDX_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_BREAK = 2'd2
  } tx_state_e;

  // Data bits carried by a frame: 5 + lc[1:0]
  function automatic int data_len(input logic [5:0] lc);
    return 5 + int'(lc[1:0]);
  endfunction

  // Total bit slots: start + data + parity + stops
  function automatic logic [IDX_W-1:0] frame_len(input logic [5:0] lc);
    return IDX_W'(7) + IDX_W'(lc[1:0]) + IDX_W'(lc[5]) + IDX_W'(lc[2]);
  endfunction

  // Parity bit for the enabled modes (lc[4:3]: odd, even, mark, space)
  function automatic logic parity_bit(input logic [5:0] lc, input logic [7:0] d);
    logic [7:0] mask;
    logic       x;
    mask = 8'hFF >> (2'd3 - lc[1:0]);
    x    = ^(d & mask);
    case (lc[4:3])
      2'b00:   return ~x;
      2'b01:   return x;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Bit slots of a frame, slot 0 first on the line; unused slots stay 1
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [5:0] lc, input logic [7:0] d);
    logic [FRAME_MAX-1:0] v;
    int dl;
    v    = '1;
    v[0] = 1'b0;
    dl   = data_len(lc);
    for (int i = 0; i < 8; i++) begin
      if (i < dl) v[1 + i] = d[i];
    end
    if (lc[5]) v[1 + dl] = parity_bit(lc, d);
    return v;
  endfunction

endpackage

// File: rtl/uftx_baud.sv
module uftx_baud #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             bit_end
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
      sub_q <= '0;
    end else if (restart) begin
      div_q <= divisor;
      pre_q <= '0;
      sub_q <= '0;
    end else if (run) begin
      if (pre_wrap) begin
        pre_q <= '0;
        sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign bit_end = run && !restart && pre_wrap && (sub_q == SUB_LAST);

endmodule

// File: rtl/uftx_shift.sv
module uftx_shift
  import uftx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_frame,
  input  logic                 load_break,
  input  logic [FRAME_MAX-1:0] frame_vec,
  input  logic [IDX_W-1:0]     slots,
  input  logic                 bit_end,
  output logic                 txd,
  output logic                 last_bit
);
  logic [FRAME_MAX-1:0] vec_q;
  logic [IDX_W-1:0]     len_q;
  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W-1:0]     idx_nxt;
  logic                 txd_q;

  assign idx_nxt  = idx_q + 1'b1;
  assign last_bit = (idx_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '1;
      len_q <= IDX_W'(1);
      idx_q <= '0;
      txd_q <= 1'b1;
    end else if (load_frame) begin
      vec_q <= frame_vec;
      len_q <= slots;
      idx_q <= '0;
      txd_q <= frame_vec[0];
    end else if (load_break) begin
      vec_q <= '0;
      len_q <= slots;
      idx_q <= '0;
      txd_q <= 1'b0;
    end else if (bit_end) begin
      if (last_bit) begin
        idx_q <= '0;
        txd_q <= 1'b1;
      end else begin
        idx_q <= idx_nxt;
        txd_q <= vec_q[idx_nxt];
      end
    end
  end

  assign txd = txd_q;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [5:0]       lcr,
  input  logic [DIV_W-1:0] divisor,
  input  logic             flow_en,
  input  logic             cts_n,
  input  logic             brk_req,
  output logic             brk_done,
  output logic             txd
);
  tx_state_e state_q;
  logic      brk_pend_q;
  logic      brk_done_q;

  // named internal events
  logic idle;
  logic busy;
  logic in_break;
  logic flow_ok;
  logic frame_start;
  logic brk_start;
  logic bit_end;
  logic last_bit;
  logic frame_done;

  logic [FRAME_MAX-1:0] frame_vec;
  logic [IDX_W-1:0]     slots;

  assign idle        = (state_q == ST_IDLE);
  assign busy        = !idle;
  assign in_break    = (state_q == ST_BREAK);
  assign flow_ok     = !flow_en || !cts_n;
  assign brk_start   = idle && (brk_req || brk_pend_q);
  assign in_ready    = idle && !brk_req && !brk_pend_q && flow_ok;
  assign frame_start = in_valid && in_ready;
  assign frame_done  = bit_end && last_bit;

  assign frame_vec = build_frame(lcr, in_data);
  assign slots     = frame_len(lcr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      brk_pend_q <= 1'b0;
      brk_done_q <= 1'b0;
    end else begin
      brk_pend_q <= (brk_pend_q || brk_req) && !brk_start;
      brk_done_q <= in_break && frame_done;
      case (state_q)
        ST_IDLE: begin
          if (brk_start)        state_q <= ST_BREAK;
          else if (frame_start) state_q <= ST_FRAME;
        end
        ST_FRAME, ST_BREAK: begin
          if (frame_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  uftx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (frame_start || brk_start),
    .run     (busy),
    .divisor (divisor),
    .bit_end (bit_end)
  );

  uftx_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_frame (frame_start),
    .load_break (brk_start),
    .frame_vec  (frame_vec),
    .slots      (slots),
    .bit_end    (bit_end),
    .txd        (txd),
    .last_bit   (last_bit)
  );

  assign brk_done = brk_done_q;

endmodule

// File: rtl/uftx_checker.sv
module uftx_checker (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic txd,
  input logic brk_req,
  input logic brk_done,
  input logic flow_en,
  input logic cts_n,
  input logic busy,
  input logic frame_start,
  input logic in_break
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!txd && busy));

  assert_ready_low_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  assert_cts_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!flow_en || !cts_n));

  assert_break_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !txd);

  assert_done_after_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |-> ($past(in_break) && !in_break));

  assert_break_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !in_ready);

endmodule

bind uart_frame_tx uftx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .txd         (txd),
  .brk_req     (brk_req),
  .brk_done    (brk_done),
  .flow_en     (flow_en),
  .cts_n       (cts_n),
  .busy        (busy),
  .frame_start (frame_start),
  .in_break    (in_break)
);

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
module tb_uart_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic [5:0]  lcr = 6'b000011;
  logic [15:0] divisor = 16'd1;
  logic        flow_en = 1'b0;
  logic        cts_n = 1'b0;
  logic        brk_req = 1'b0;
  logic        brk_done;
  logic        txd;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int done_seen = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .lcr(lcr), .divisor(divisor), .flow_en(flow_en),
    .cts_n(cts_n), .brk_req(brk_req), .brk_done(brk_done), .txd(txd)
  );

  // ---------------- behavioural reference model ----------------
  bit q[$];
  bit m_pend = 0;
  bit m_brk = 0;
  bit exp_done = 0;

  function automatic int slot_count(input logic [5:0] lc);
    int n;
    n = 1 + 5 + lc[1:0] + 1;
    if (lc[5]) n++;
    if (lc[2]) n++;
    return n;
  endfunction

  task automatic push_bit(input bit b, input int p);
    for (int k = 0; k < p; k++) q.push_back(b);
  endtask

  task automatic push_frame(input logic [5:0] lc, input logic [7:0] d, input int p);
    int dl;
    int ones;
    bit par;
    dl = 5 + lc[1:0];
    ones = 0;
    push_bit(1'b0, p);
    for (int i = 0; i < dl; i++) begin
      push_bit(d[i], p);
      if (d[i]) ones++;
    end
    if (lc[5]) begin
      case (lc[4:3])
        2'b00: par = (ones % 2 == 0);
        2'b01: par = (ones % 2 == 1);
        2'b10: par = 1'b1;
        default: par = 1'b0;
      endcase
      push_bit(par, p);
    end
    push_bit(1'b1, p);
    if (lc[2]) push_bit(1'b1, p);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_pend = 0;
      m_brk = 0;
      exp_done = 0;
    end else begin
      bit was_empty;
      bit s_brk;
      bit s_frm;
      int p;
      was_empty = (q.size() == 0);
      exp_done = 0;
      if (!was_empty) begin
        void'(q.pop_front());
        if (q.size() == 0 && m_brk) begin
          exp_done = 1;
          m_brk = 0;
        end
      end
      s_brk = was_empty && (brk_req || m_pend);
      s_frm = was_empty && !s_brk && in_valid && (!flow_en || !cts_n);
      m_pend = (m_pend || brk_req) && !s_brk;
      p = (int'(divisor) + 1) * 16;
      if (s_brk) begin
        push_bit(1'b0, p * slot_count(lcr));
        m_brk = 1;
      end else if (s_frm) begin
        push_frame(lcr, in_data, p);
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_txd;
      bit e_rdy;
      e_txd = (q.size() == 0) ? 1'b1 : q[0];
      e_rdy = (q.size() == 0) && !m_pend && !brk_req && (!flow_en || !cts_n);
      checks++;
      if (txd !== e_txd || in_ready !== e_rdy || brk_done !== exp_done) begin
        failures++;
        $display("FAIL %s t=%0t txd/ready/done actual=%b%b%b expected=%b%b%b",
                 cur_req, $time, txd, in_ready, brk_done, e_txd, e_rdy, exp_done);
      end
      if (brk_done === 1'b1) done_seen++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    bit r;
    in_data = d;
    in_valid = 1'b1;
    forever begin
      @(negedge clk) r = in_ready;
      @(posedge clk);
      if (r) break;
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0 || m_pend) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int d0;
    int low;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle txd", txd === 1'b1, txd, 1);
    check("R1 idle ready", in_ready === 1'b1, in_ready, 1);
    @(posedge clk); #1;

    cur_req = "R2 R5 8N1";
    lcr = 6'b000011; divisor = 16'd1;
    send(8'hA5); wait_idle();
    send(8'h3C); send(8'hFF); wait_idle();

    cur_req = "R3 R4 5E2"; lcr = 6'b101100; divisor = 16'd0;
    send(8'h13); send(8'h0E); wait_idle();

    cur_req = "R3 7O1"; lcr = 6'b100010; divisor = 16'd2;
    send(8'h55); send(8'h40); wait_idle();

    cur_req = "R3 R4 6 mark 2"; lcr = 6'b110101; divisor = 16'd0;
    send(8'h2A); wait_idle();

    cur_req = "R3 8 space"; lcr = 6'b111011; divisor = 16'd0;
    send(8'hC3); wait_idle();

    // R6: ready low during frame, measured at the port
    cur_req = "R6"; lcr = 6'b000011; divisor = 16'd0;
    send(8'h81);
    low = 0;
    repeat (100) begin @(negedge clk); if (!in_ready) low++; end
    check("R6 ready low in frame", low == 100, low, 100);
    wait_idle();

    // R7: change format and divisor in mid-frame
    cur_req = "R7"; lcr = 6'b000011; divisor = 16'd1;
    send(8'h96);
    repeat (40) @(posedge clk);
    #1 lcr = 6'b101100; divisor = 16'd3;
    wait_idle();
    lcr = 6'b000011; divisor = 16'd0;

    // R8: clear-to-send gating
    cur_req = "R8"; flow_en = 1'b1; cts_n = 1'b1;
    in_data = 8'h5A; in_valid = 1'b1;
    low = 0;
    repeat (60) begin @(negedge clk); if (txd === 1'b1 && in_ready === 1'b0) low++; end
    check("R8 blocked by cts", low == 60, low, 60);
    @(posedge clk); #1 cts_n = 1'b0;
    @(posedge clk); #1 in_valid = 1'b0;
    wait_idle();
    flow_en = 1'b0;

    // R9: break queued behind a running frame
    cur_req = "R9"; lcr = 6'b000011; divisor = 16'd0;
    d0 = done_seen;
    send(8'hF0);
    repeat (20) @(posedge clk);
    #1 brk_req = 1'b1;
    @(posedge clk); #1 brk_req = 1'b0;
    wait_idle();
    check("R9 one done pulse", done_seen == d0 + 1, done_seen, d0 + 1);

    // R10: break and data offered together while idle
    cur_req = "R10"; lcr = 6'b100111; divisor = 16'd0;
    d0 = done_seen;
    in_data = 8'h6D; in_valid = 1'b1; brk_req = 1'b1;
    @(posedge clk); #1 brk_req = 1'b0;
    @(negedge clk);
    check("R10 ready held during break", in_ready === 1'b0, in_ready, 0);
    while (done_seen == d0) @(posedge clk);
    check("R10 break done before data", done_seen == d0 + 1, done_seen, d0 + 1);
    @(posedge clk); #1 in_valid = 1'b0;
    wait_idle();

    check("R9 total done pulses", done_seen == 2, done_seen, 2);
    finish_run();
  end

endmodule